// File: doc/BRIEF.md
# Resistive Touch Measurement Sequencer

This block runs automatic measurement cycles for a four-wire resistive touch panel. It is paced by a slow tick (one clock-enable pulse per cycle of a 32768 Hz reference), and steps through a fixed sequence of phases for every position pair. The sequence biases the X plate, converts X, biases the Y plate, converts Y, then checks for pen contact and waits. Each phase length is taken from a programmable interval register and counted in ticks. The block drives the panel bias selects and a start strobe towards an external ADC interface, takes the 10-bit results back, and packs each X/Y pair with a pen flag into one 32-bit word for a downstream FIFO.

Software sets the block up through a simple write port. A control word holds the enable and power-up bits and the per-axis resolution codes. The interval registers and a min/max window per axis are also written through this port. A pair whose X or Y lies outside the window is dropped. While the pen is up, the sequencer alternates between pen detection and the pen-up wait, and starts no conversions.

Top module: `touch_seq`

## Requirements
- R1: After reset all drive outputs, `adcStart`, `adcPowerUp` and `outValid` are 0, and `outWord` is 0.
- R2: For a pair, the phases run in the order X settle (`driveX`), X conversion (`driveX`), Y settle (`driveY`, `adcChanY`), Y conversion (`driveY`, `adcChanY`), pen detect (`drivePen`), touch wait, and pen-up wait. Only the first five phases drive a bias output. After the pen-up wait a new pair begins with X settle if the last pen detect saw the pen down.
- R3: On entry, every timed phase loads its counter from its register. The counter drops by one on each `tick` and the phase ends in the clock cycle after the counter reaches zero. A phase of length zero lasts exactly one clock cycle.
- R4: A conversion phase first counts the conversion-delay interval in ticks. It then gives one single-cycle `adcStart` and ends on the next `adcDone`. An `adcDone` that arrives while no conversion is outstanding has no effect.
- R5: One clock cycle after the pen-detect phase that follows a pair ends, `outValid` pulses for one cycle. At that point `outWord` carries X in bits 25:16 and Y in bits 9:0. Bit 31 is 1 when `penSense` was low (pen up) at the end of pen detect. All other bits are 0.
- R6: The control word holds the X resolution code in bits 9:7 and the Y resolution code in bits 6:4. A code c keeps the upper 10-c bits of the result and clears the lower c bits, so code 0 is a full 10-bit sample.
- R7: A pair is emitted only when minX <= X <= maxX and minY <= Y <= maxY, with both bounds inclusive. Otherwise the pair is dropped and `outValid` stays 0.
- R8: When pen detect sees `penSense` low, the sequencer goes to the pen-up wait and then back to pen detect. It repeats this without any `adcStart` until the pen is seen down.
- R9: Control bit 0 enables automatic capture and bit 2 powers up the ADC; `adcPowerUp` follows bit 2. From idle, capture starts at pen detect one cycle after both bits are seen set. If either bit is cleared, the sequencer finishes the current phase and goes idle with all drives low.
- R10: The write port uses these addresses: 0 control, 1 settle, 2 conversion delay, 3 pen detect, 4 touch wait, 5 pen-up wait, 6 minX, 7 maxX, 8 minY, 9 maxY. Writes to other addresses are ignored. Reset values are settle 2, delay 2, pen detect 4, touch wait 16, pen-up wait 88, minima 0, maxima 0x3FF and control 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 32768 Hz reference period |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write address |
| regWrData | input | 10 | Register write data |
| penSense | input | 1 | Pen contact comparator, 1 = pen down (synchronous to clk) |
| adcDone | input | 1 | Conversion finished pulse |
| adcResult | input | 10 | Conversion result, valid with adcDone |
| adcPowerUp | output | 1 | ADC power-up control |
| adcStart | output | 1 | Start-conversion strobe |
| adcChanY | output | 1 | Channel select, 1 = Y axis phases |
| driveX | output | 1 | Bias the X plate |
| driveY | output | 1 | Bias the Y plate |
| drivePen | output | 1 | Bias for pen detection |
| outValid | output | 1 | Packed word valid pulse |
| outWord | output | 32 | Packed pen flag, X and Y |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 8-bit interval counters and a 4-bit address. It pulses `tick` once every four clocks. One pair runs with the reset interval values. After that the bench writes short intervals, including zero-length pen detect and touch wait phases. This puts many pairs, the pen-up loop, the skipped phases, the window boundaries and a stop and restart within the cycle budget. An ADC responder answers each start three cycles later, and a stray done pulse is injected while no conversion is outstanding.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETX  = 3'd1,
    PH_CONVX = 3'd2,
    PH_SETY  = 3'd3,
    PH_CONVY = 3'd4,
    PH_PDET  = 3'd5,
    PH_TWAIT = 3'd6,
    PH_UWAIT = 3'd7
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchX;
    logic latchY;
    logic emit;
    logic penUp;
  } dp_strobe_t;

endpackage

// File: rtl/touch_seq_regs.sv
module touch_seq_regs #(
  parameter int DATA_W     = 10,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 4,
  parameter int CODE_W     = 3,
  parameter int DEF_SETTLE = 2,
  parameter int DEF_DELAY  = 2,
  parameter int DEF_PDET   = 4,
  parameter int DEF_TWAIT  = 16,
  parameter int DEF_UWAIT  = 88
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                autoEn,
  output logic                powerUp,
  output logic [CODE_W-1:0]   resXCode,
  output logic [CODE_W-1:0]   resYCode,
  output logic [CNT_W-1:0]    lenSettle,
  output logic [CNT_W-1:0]    lenDelay,
  output logic [CNT_W-1:0]    lenPdet,
  output logic [CNT_W-1:0]    lenTwait,
  output logic [CNT_W-1:0]    lenUwait,
  output logic [DATA_W-1:0]   minX,
  output logic [DATA_W-1:0]   maxX,
  output logic [DATA_W-1:0]   minY,
  output logic [DATA_W-1:0]   maxY
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DELAY  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PDET   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TWAIT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_UWAIT  = ADDR_W'(5);
  localparam int                WIN_BASE = 6;
  localparam int                N_WIN    = 4;
  localparam int                YRES_LSB = 4;
  localparam int                XRES_LSB = YRES_LSB + CODE_W;

  // Control word fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoEn   <= 1'b0;
      powerUp  <= 1'b0;
      resXCode <= '0;
      resYCode <= '0;
    end else if (wrEn && wrAddr == A_CTRL) begin
      autoEn   <= wrData[0];
      powerUp  <= wrData[2];
      resYCode <= wrData[YRES_LSB +: CODE_W];
      resXCode <= wrData[XRES_LSB +: CODE_W];
    end
  end

  // Interval registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenSettle <= CNT_W'(DEF_SETTLE);
      lenDelay  <= CNT_W'(DEF_DELAY);
      lenPdet   <= CNT_W'(DEF_PDET);
      lenTwait  <= CNT_W'(DEF_TWAIT);
      lenUwait  <= CNT_W'(DEF_UWAIT);
    end else if (wrEn) begin
      case (wrAddr)
        A_SETTLE: lenSettle <= wrData[CNT_W-1:0];
        A_DELAY:  lenDelay  <= wrData[CNT_W-1:0];
        A_PDET:   lenPdet   <= wrData[CNT_W-1:0];
        A_TWAIT:  lenTwait  <= wrData[CNT_W-1:0];
        A_UWAIT:  lenUwait  <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // Window registers: even slots are minima (reset 0), odd slots maxima (reset all ones)
  logic [DATA_W-1:0] winReg [N_WIN];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(WIN_BASE + g);
    localparam logic [DATA_W-1:0] SLOT_RST  = (g % 2 == 0) ? '0 : '1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             winReg[g] <= SLOT_RST;
      else if (wrEn && wrAddr == SLOT_ADDR)   winReg[g] <= wrData;
    end
  end

  assign minX = winReg[0];
  assign maxX = winReg[1];
  assign minY = winReg[2];
  assign maxY = winReg[3];

endmodule

// File: rtl/touch_seq_ctrl.sv
module touch_seq_ctrl
  import touch_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] lenSettle,
  input  logic [CNT_W-1:0] lenDelay,
  input  logic [CNT_W-1:0] lenPdet,
  input  logic [CNT_W-1:0] lenTwait,
  input  logic [CNT_W-1:0] lenUwait,
  input  logic             penSense,
  input  logic             adcDone,
  output logic             adcStart,
  output logic             adcChanY,
  output logic             driveX,
  output logic             driveY,
  output logic             drivePen,
  output dp_strobe_t       strobe
);

  phase_t           phase, nextPhase;
  logic [CNT_W-1:0] cnt, nextLen;
  logic             convWait, pairPending, penDown;
  logic             isConv, isTimed, phaseDone;

  assign isConv    = (phase == PH_CONVX) || (phase == PH_CONVY);
  assign isTimed   = (phase != PH_IDLE) && !isConv;
  assign phaseDone = isConv ? (convWait && adcDone) : (isTimed && cnt == '0);
  assign adcStart  = isConv && (cnt == '0) && !convWait;

  always_comb begin
    unique case (phase)
      PH_SETX:  nextPhase = PH_CONVX;
      PH_CONVX: nextPhase = PH_SETY;
      PH_SETY:  nextPhase = PH_CONVY;
      PH_CONVY: nextPhase = PH_PDET;
      PH_PDET:  nextPhase = penSense ? PH_TWAIT : PH_UWAIT;
      PH_TWAIT: nextPhase = PH_UWAIT;
      PH_UWAIT: nextPhase = penDown ? PH_SETX : PH_PDET;
      default:  nextPhase = PH_PDET;
    endcase
  end

  always_comb begin
    unique case (nextPhase)
      PH_SETX, PH_SETY:   nextLen = lenSettle;
      PH_CONVX, PH_CONVY: nextLen = lenDelay;
      PH_PDET:            nextLen = lenPdet;
      PH_TWAIT:           nextLen = lenTwait;
      PH_UWAIT:           nextLen = lenUwait;
      default:            nextLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      convWait    <= 1'b0;
      pairPending <= 1'b0;
      penDown     <= 1'b0;
    end else if (phase == PH_IDLE) begin
      convWait <= 1'b0;
      if (run) begin
        phase <= PH_PDET;
        cnt   <= lenPdet;
      end
    end else if (phaseDone) begin
      convWait <= 1'b0;
      if (phase == PH_CONVY)     pairPending <= 1'b1;
      else if (phase == PH_PDET) pairPending <= 1'b0;
      if (phase == PH_PDET)      penDown <= penSense;
      if (run) begin
        phase <= nextPhase;
        cnt   <= nextLen;
      end else begin
        phase       <= PH_IDLE;
        cnt         <= '0;
        pairPending <= 1'b0;
      end
    end else begin
      if (adcStart) convWait <= 1'b1;
      if (cnt != '0 && tick) cnt <= cnt - 1'b1;
    end
  end

  assign driveX   = (phase == PH_SETX) || (phase == PH_CONVX);
  assign driveY   = (phase == PH_SETY) || (phase == PH_CONVY);
  assign adcChanY = driveY;
  assign drivePen = (phase == PH_PDET);

  always_comb begin
    strobe.latchX = (phase == PH_CONVX) && phaseDone;
    strobe.latchY = (phase == PH_CONVY) && phaseDone;
    strobe.emit   = (phase == PH_PDET) && phaseDone && pairPending;
    strobe.penUp  = !penSense;
  end

  // R4: a start strobe never lasts two cycles
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |=> !adcStart);

  // R2: a Y start only happens with the Y plate biased
  p_y_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adcStart && adcChanY) |-> (driveY && !driveX));

  // R9: finishing a phase with capture disabled returns to idle
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseDone && !run) |=> (phase == PH_IDLE));

  // R3: counter only moves on a tick
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (isTimed && !phaseDone && !tick) |=> $stable(cnt));

  // R8: pen-up loop does not start a conversion
  p_penup_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_UWAIT && !penDown) |=> !adcStart);

endmodule

// File: rtl/touch_seq_dp.sv
module touch_seq_dp
  import touch_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CODE_W = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] adcResult,
  input  logic [CODE_W-1:0] resXCode,
  input  logic [CODE_W-1:0] resYCode,
  input  logic [DATA_W-1:0] minX,
  input  logic [DATA_W-1:0] maxX,
  input  logic [DATA_W-1:0] minY,
  input  logic [DATA_W-1:0] maxY,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);

  localparam int X_LSB   = 16;
  localparam int PEN_BIT = WORD_W - 1;

  logic [DATA_W-1:0] xVal, yVal, xMasked, yMasked;
  logic              inWin;
  logic [WORD_W-1:0] packWord;

  // Resolution: drop the lowest code bits of the result
  assign xMasked = adcResult & ({DATA_W{1'b1}} << resXCode);
  assign yMasked = adcResult & ({DATA_W{1'b1}} << resYCode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xVal <= '0;
      yVal <= '0;
    end else begin
      if (strobe.latchX) xVal <= xMasked;
      if (strobe.latchY) yVal <= yMasked;
    end
  end

  assign inWin = (xVal >= minX) && (xVal <= maxX) &&
                 (yVal >= minY) && (yVal <= maxY);

  always_comb begin
    packWord                  = '0;
    packWord[PEN_BIT]         = strobe.penUp;
    packWord[X_LSB +: DATA_W] = xVal;
    packWord[0 +: DATA_W]     = yVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strobe.emit && inWin;
      if (strobe.emit && inWin) outWord <= packWord;
    end
  end

  // R7: an emitted word lies inside the window that was in force
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outWord[X_LSB +: DATA_W] >= $past(minX) &&
                  outWord[X_LSB +: DATA_W] <= $past(maxX) &&
                  outWord[DATA_W-1:0]      >= $past(minY) &&
                  outWord[DATA_W-1:0]      <= $past(maxY)));

  // R5: unused word bits stay clear
  p_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outWord[PEN_BIT-1:X_LSB+DATA_W] == '0 &&
                  outWord[X_LSB-1:DATA_W] == '0));

endmodule

// File: rtl/touch_seq.sv
module touch_seq
  import touch_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              penSense,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcResult,
  output logic              adcPowerUp,
  output logic              adcStart,
  output logic              adcChanY,
  output logic              driveX,
  output logic              driveY,
  output logic              drivePen,
  output logic              outValid,
  output logic [31:0]       outWord
);

  localparam int CODE_W = 3;

  logic              autoEn, powerUp;
  logic [CODE_W-1:0] resXCode, resYCode;
  logic [CNT_W-1:0]  lenSettle, lenDelay, lenPdet, lenTwait, lenUwait;
  logic [DATA_W-1:0] minX, maxX, minY, maxY;
  dp_strobe_t        strobe;

  touch_seq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .autoEn(autoEn), .powerUp(powerUp), .resXCode(resXCode), .resYCode(resYCode),
    .lenSettle(lenSettle), .lenDelay(lenDelay), .lenPdet(lenPdet),
    .lenTwait(lenTwait), .lenUwait(lenUwait),
    .minX(minX), .maxX(maxX), .minY(minY), .maxY(maxY));

  touch_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(autoEn && powerUp),
    .lenSettle(lenSettle), .lenDelay(lenDelay), .lenPdet(lenPdet),
    .lenTwait(lenTwait), .lenUwait(lenUwait),
    .penSense(penSense), .adcDone(adcDone),
    .adcStart(adcStart), .adcChanY(adcChanY),
    .driveX(driveX), .driveY(driveY), .drivePen(drivePen), .strobe(strobe));

  touch_seq_dp #(.DATA_W(DATA_W), .CODE_W(CODE_W), .WORD_W(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .adcResult(adcResult),
    .resXCode(resXCode), .resYCode(resYCode),
    .minX(minX), .maxX(maxX), .minY(minY), .maxY(maxY),
    .outValid(outValid), .outWord(outWord));

  assign adcPowerUp = powerUp;

endmodule

// File: tb/touch_seq_bench.sv
module touch_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [9:0]  regWrData = '0;
  logic        penSense = 1'b1;
  logic        respDone = 1'b0, strayDone = 1'b0;
  logic        adcDone;
  logic [9:0]  adcResult = '0;
  logic        adcPowerUp, adcStart, adcChanY, driveX, driveY, drivePen, outValid;
  logic [31:0] outWord;

  assign adcDone = respDone | strayDone;

  touch_seq u_touch_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .penSense(penSense), .adcDone(adcDone), .adcResult(adcResult),
    .adcPowerUp(adcPowerUp), .adcStart(adcStart), .adcChanY(adcChanY),
    .driveX(driveX), .driveY(driveY), .drivePen(drivePen),
    .outValid(outValid), .outWord(outWord));

  always #4 clk = ~clk;   // 125 MHz

  int nChecks = 0, nFails = 0, cycles = 0;
  int words = 0, starts = 0, penRun = 0, lastPenRun = 0, tickCnt = 0, respWait = 0;
  logic [9:0] xv = 10'h155, yv = 10'h2AA;
  int driveLog[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         mPh, mCnt;
  bit         mWait, mPair, mPenDn, mOutV;
  bit [31:0]  mOutW;
  bit [9:0]   mX, mY;
  bit [31:0]  rg[16];

  function automatic bit [9:0] keepTop(bit [9:0] v, int code);
    return bit'(1) ? ((v >> code) << code) : v;
  endfunction

  function automatic int lenFor(int p);
    case (p)
      1, 3: return rg[1];
      2, 4: return rg[2];
      5:    return rg[3];
      6:    return rg[4];
      7:    return rg[5];
      default: return 0;
    endcase
  endfunction

  bit mConv, mDone, mEmit, mRun, mWin;
  int mNext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPh = 0; mCnt = 0; mWait = 0; mPair = 0; mPenDn = 0; mOutV = 0; mOutW = 0;
      mX = 0; mY = 0;
      foreach (rg[i]) rg[i] = 0;
      rg[1] = 2; rg[2] = 2; rg[3] = 4; rg[4] = 16; rg[5] = 88;
      rg[7] = 10'h3FF; rg[9] = 10'h3FF;
    end else begin
      mRun  = rg[0][0] && rg[0][2];
      mConv = (mPh == 2 || mPh == 4);
      mDone = mConv ? (mWait && adcDone) : (mPh != 0 && mCnt == 0);
      mEmit = 0;
      if (mPh == 0) begin
        mWait = 0;
        if (mRun) begin mPh = 5; mCnt = rg[3]; end
      end else if (mDone) begin
        mWait = 0;
        mEmit = (mPh == 5) && mPair;
        if (mPh == 2) mX = keepTop(adcResult, int'(rg[0][9:7]));
        if (mPh == 4) mY = keepTop(adcResult, int'(rg[0][6:4]));
        if (mPh == 4) mPair = 1; else if (mPh == 5) mPair = 0;
        case (mPh)
          5: mNext = penSense ? 6 : 7;
          7: mNext = mPenDn ? 1 : 5;
          default: mNext = mPh + 1;
        endcase
        if (mPh == 5) mPenDn = penSense;
        if (mRun) begin mPh = mNext; mCnt = lenFor(mNext); end
        else begin mPh = 0; mCnt = 0; mPair = 0; end
      end else begin
        if (mConv && mCnt == 0 && !mWait) mWait = 1;
        if (mCnt != 0 && tick) mCnt--;
      end
      mWin  = (mX >= rg[6][9:0]) && (mX <= rg[7][9:0]) && (mY >= rg[8][9:0]) && (mY <= rg[9][9:0]);
      mOutV = mEmit && mWin;
      if (mOutV) mOutW = {!penSense, 5'd0, mX, 6'd0, mY};
      if (regWrEn) begin
        case (regAddr)
          4'd0: rg[0] = {22'd0, regWrData};
          4'd1, 4'd2, 4'd3, 4'd4, 4'd5: rg[regAddr] = {24'd0, regWrData[7:0]};
          4'd6, 4'd7, 4'd8, 4'd9: rg[regAddr] = {22'd0, regWrData};
          default: ;
        endcase
      end
    end
  end

  // ---------- per-cycle compare, tick generator, ADC responder ----------
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 driveX",   driveX,   (mPh == 1 || mPh == 2));
      chk("R2 driveY",   driveY,   (mPh == 3 || mPh == 4));
      chk("R2 drivePen", drivePen, (mPh == 5));
      chk("R2 adcChanY", adcChanY, (mPh == 3 || mPh == 4));
      chk("R4 adcStart", adcStart, ((mPh == 2 || mPh == 4) && mCnt == 0 && !mWait));
      chk("R9 adcPowerUp", adcPowerUp, rg[0][2]);
      chk("R7 outValid", outValid, mOutV);
      chk("R5 outWord",  outWord,  mOutW);
      if (outValid) words++;
      if (adcStart) starts++;
      if (drivePen) penRun++;
      else if (penRun != 0) begin lastPenRun = penRun; penRun = 0; end
      if (driveLog.size() == 0 || driveLog[$] != int'({drivePen, driveY, driveX}))
        driveLog.push_back(int'({drivePen, driveY, driveX}));
    end
    tick    <= (tickCnt == 3);
    tickCnt  = (tickCnt + 1) % 4;
    respDone  <= 1'b0;
    if (respWait > 0) begin
      respWait--;
      if (respWait == 0) begin
        respDone  <= 1'b1;
        adcResult <= adcChanY ? yv : xv;
      end
    end
    if (adcStart) respWait = 3;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = 10'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitWords(int n, int limit);
    int base = words;
    for (int i = 0; i < limit && words < base + n; i++) @(negedge clk);
  endtask

  task automatic idleFor(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int w0, s0;
    idleFor(3);
    // R1: reset state
    chk("R1 drives", {28'd0, driveX, driveY, drivePen, adcStart}, 32'd0);
    chk("R1 outValid/powerUp", {30'd0, outValid, adcPowerUp}, 32'd0);
    chk("R1 outWord", outWord, 32'd0);
    rst_n = 1'b1;
    idleFor(2);
    chk("R1 after release", {27'd0, driveX, driveY, drivePen, adcStart, outValid}, 32'd0);

    // R10 ignored address, R9 enable without power does not start
    wr(13, 10'h3FF);
    wr(0, 10'h001);
    idleFor(20);
    chk("R9 no start without power", {29'd0, driveX, driveY, drivePen}, 32'd0);

    // R2/R5/R10: one pair with reset intervals, pen down
    driveLog.delete();
    wr(0, 10'h005);
    @(negedge clk);
    chk("R9 start at pen detect", drivePen, 1'b1);
    waitWords(1, 3000);
    chk("R10 default intervals give a word", 32'(words), 32'd1);
    chk("R5 packed word", outWord, 32'h015502AA);
    chk("R2 order Pen", (driveLog.size() > 5) ? driveLog[1] : -1, 4);
    chk("R2 order idle", (driveLog.size() > 5) ? driveLog[2] : -1, 0);
    chk("R2 order X", (driveLog.size() > 5) ? driveLog[3] : -1, 1);
    chk("R2 order Y", (driveLog.size() > 5) ? driveLog[4] : -1, 2);
    chk("R2 order Pen again", (driveLog.size() > 5) ? driveLog[5] : -1, 4);

    // R3: short intervals, zero-length delay and touch wait
    wr(1, 1); wr(2, 0); wr(3, 1); wr(4, 0); wr(5, 3);
    w0 = words;
    waitWords(4, 3000);
    chk("R3 short intervals keep producing", 32'(words - w0), 32'd4);

    // R6: resolution codes X=3, Y=1
    yv = 10'h2AB;
    wr(0, (3 << 7) | (1 << 4) | 5);
    waitWords(3, 3000);
    chk("R6 resolution masking", outWord, 32'h015002AA);

    // R7: window excludes, then inclusive boundary
    wr(0, 10'h005);
    wr(6, 10'h200);
    idleFor(10);
    w0 = words; s0 = starts;
    idleFor(600);
    chk("R7 outside window dropped", 32'(words - w0), 32'd0);
    chk("R7 conversions still ran", 32'(starts - s0 > 0), 32'd1);
    wr(6, 10'h155); wr(9, 10'h2AB);
    waitWords(2, 3000);
    chk("R7 inclusive bound", outWord, 32'h015502AB);

    // R8/R5: pen lifted -> one pen-up word, then no conversions
    penSense = 1'b0;
    w0 = words;
    for (int i = 0; i < 3000 && !(outValid && outWord[31]); i++) @(negedge clk);
    chk("R5 pen-up flag", outWord[31], 1'b1);
    idleFor(40);
    w0 = words; s0 = starts;
    idleFor(400);
    chk("R8 no starts while pen up", 32'(starts - s0), 32'd0);
    chk("R8 no words while pen up", 32'(words - w0), 32'd0);

    // R3: zero-length pen detect lasts one cycle
    wr(3, 0);
    idleFor(100);
    chk("R3 zero-length phase", 32'(lastPenRun), 32'd1);

    // R4: stray done while no conversion outstanding
    s0 = starts; w0 = words;
    @(negedge clk); strayDone = 1'b1;
    @(negedge clk); strayDone = 1'b0;
    idleFor(100);
    chk("R4 stray done ignored", 32'(words - w0 + starts - s0), 32'd0);

    // pen down again resumes
    penSense = 1'b1;
    w0 = words;
    waitWords(2, 3000);
    chk("R8 capture resumes", 32'(words - w0), 32'd2);

    // R9: stop after current phase, then power off
    wr(0, 10'h004);
    idleFor(200);
    s0 = starts;
    idleFor(200);
    chk("R9 stopped drives", {28'd0, driveX, driveY, drivePen, adcStart}, 32'd0);
    chk("R9 stopped no starts", 32'(starts - s0), 32'd0);
    chk("R9 power bit kept", adcPowerUp, 1'b1);
    wr(0, 10'h000);
    @(negedge clk);
    chk("R9 power bit cleared", adcPowerUp, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule